// File: doc/BRIEF.md
# SDRAM Extended-Mode Update Sequencer

This block serves the periodic refresh slot of a low-power SDRAM controller. On each refresh request from the arbiter it issues an auto-refresh. If the low-power settings have changed since the last rewrite, it first rewrites the extended mode register in the same slot. The settings are the partial-array refresh mask, the temperature-compensation code and the output drive strength. In that case it issues a precharge-all, then a mode-register-set, and then the auto-refresh. New settings therefore take effect without a separate maintenance pause in traffic.

Between commands the block drives NOP. It waits programmable gaps: the precharge-to-mode-set gap, the mode-set-to-refresh gap and the refresh recovery time. When the recovery time has elapsed, it returns a one-cycle done pulse to the arbiter. CKE is held high at all times.

Top module: `emr_refresh_seq`

## Requirements
- R1: After reset, cmd_o is NOP (3'b111, encoding {ras_n,cas_n,we_n}), ba_o and addr_o are zero, cke_o is 1 and done_o is 0.
- R2: With no update pending, a request sampled high while idle gives an auto-refresh (3'b001) in the next cycle, and no precharge or mode-set in that slot.
- R3: With an update pending, a request sampled high while idle gives a precharge-all (3'b010) in the next cycle, then a mode-set (3'b000), then an auto-refresh, in that order.
- R4: The mode-set comes exactly eff(t_rp_i) cycles after the precharge-all, with NOP and zero bus values in between.
- R5: The auto-refresh comes exactly eff(t_mrd_i) cycles after the mode-set, with NOP in between.
- R6: After the auto-refresh, NOP is driven for eff(t_rfc_i) cycles. done_o is high for exactly one cycle, on the last of them.
- R7: eff(t) equals t for t in 1..15, and equals 1 for t = 0.
- R8: During the mode-set, ba_o is 2 and addr_o is {6'b0, ds_i[1:0], tcr_i[1:0], pasr_i[2:0]}. This places pasr in bits 2:0, tcr in bits 4:3 and ds in bits 6:5.
- R9: During the precharge-all, addr_o has only bit 10 set and ba_o is 0.
- R10: cke_o is 1 in every cycle. Every cycle without another command carries NOP with ba_o and addr_o at 0.
- R11: A pulse on cfg_changed_i sets the pending flag. The flag clears only when an update sequence completes. A change reported during an update sequence keeps the flag set after that sequence ends.
- R12: A request arriving while a sequence is running is ignored. After done, the block stays idle until a new request arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| refresh_req_i | input | 1 | Refresh request from the arbiter, sampled while idle |
| cfg_changed_i | input | 1 | Pulse: extended-mode settings have changed |
| pasr_i | input | 3 | Partial-array refresh mask |
| tcr_i | input | 2 | Temperature-compensation code |
| ds_i | input | 2 | Drive-strength code |
| t_rp_i | input | 4 | Precharge-to-mode-set gap in cycles |
| t_mrd_i | input | 4 | Mode-set-to-refresh gap in cycles |
| t_rfc_i | input | 4 | Refresh recovery time in cycles |
| cmd_o | output | 3 | SDRAM command {ras_n,cas_n,we_n} |
| ba_o | output | 2 | Bank address |
| addr_o | output | 13 | Address bus |
| cke_o | output | 1 | Clock enable |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench sweeps each of the three gap counts over every value from 0 to 15, both with and without an update pending, and checks every bus value in every cycle of the slot.

These sweeps target several faults:
- Off-by-one gap counting would shift a command by one cycle.
- A zero count taken literally would collapse a gap or make the counter wrap.
- A done pulse misplaced relative to the recovery time would show up in the wrong cycle.

A settings change injected in the middle of an update sequence exposes a flag that clears blindly at completion: the following slot would then skip the rewrite. A request injected while the block is busy exposes a sequencer that queues or restarts, which would emit unexpected commands after done.

// File: rtl/emr_seq_pkg.sv
package emr_seq_pkg;
  typedef enum logic [2:0] {
    CMD_MRS = 3'b000,
    CMD_REF = 3'b001,
    CMD_PRE = 3'b010,
    CMD_NOP = 3'b111
  } sdram_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_MRS,
    ST_REF,
    ST_GAP
  } seq_state_e;
endpackage

// File: rtl/emr_gap_timer.sv
module emr_gap_timer #(
  parameter int unsigned CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          zero_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/emr_pending_flag.sv
module emr_pending_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic change_i,
  input  logic upd_busy_i,
  input  logic upd_done_i,
  output logic pending_o
);
  logic pend_q, renew_q;

  // changes seen while an update runs must survive its completion
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      renew_q <= 1'b0;
    end else if (upd_done_i) begin
      pend_q  <= renew_q | change_i;
      renew_q <= 1'b0;
    end else begin
      if (change_i) pend_q <= 1'b1;
      if (change_i && upd_busy_i) renew_q <= 1'b1;
    end
  end

  assign pending_o = pend_q;
endmodule

// File: rtl/emr_seq_fsm.sv
module emr_seq_fsm
  import emr_seq_pkg::*;
#(
  parameter int unsigned CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          pending_i,
  input  logic [CW-1:0] t_rp_i,
  input  logic [CW-1:0] t_mrd_i,
  input  logic [CW-1:0] t_rfc_i,
  input  logic          tmr_zero_i,
  output logic          tmr_load_o,
  output logic [CW-1:0] tmr_val_o,
  output seq_state_e    state_o,
  output logic          upd_busy_o,
  output logic          done_o,
  output logic          upd_done_o
);
  seq_state_e state_q, state_d, after_q, after_d;
  logic       upd_q, upd_d;
  logic [CW-1:0] rp_eff, mrd_eff, rfc_eff;

  function automatic logic [CW-1:0] eff(input logic [CW-1:0] t);
    return (t == '0) ? CW'(1) : t;
  endfunction

  assign rp_eff  = eff(t_rp_i);
  assign mrd_eff = eff(t_mrd_i);
  assign rfc_eff = eff(t_rfc_i);

  always_comb begin
    state_d    = state_q;
    after_d    = after_q;
    upd_d      = upd_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    done_o     = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_i) begin
        upd_d   = pending_i;
        state_d = pending_i ? ST_PRE : ST_REF;
      end
      ST_PRE: begin
        after_d = ST_MRS;
        if (rp_eff == CW'(1)) state_d = ST_MRS;
        else begin
          state_d    = ST_GAP;
          tmr_load_o = 1'b1;
          tmr_val_o  = rp_eff - CW'(2);
        end
      end
      ST_MRS: begin
        after_d = ST_REF;
        if (mrd_eff == CW'(1)) state_d = ST_REF;
        else begin
          state_d    = ST_GAP;
          tmr_load_o = 1'b1;
          tmr_val_o  = mrd_eff - CW'(2);
        end
      end
      ST_REF: begin
        // recovery gap is a full rfc_eff cycles of NOP
        after_d    = ST_IDLE;
        state_d    = ST_GAP;
        tmr_load_o = 1'b1;
        tmr_val_o  = rfc_eff - CW'(1);
      end
      ST_GAP: if (tmr_zero_i) begin
        state_d = after_q;
        if (after_q == ST_IDLE) begin
          done_o = 1'b1;
          upd_d  = 1'b0;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      after_q <= ST_IDLE;
      upd_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      after_q <= after_d;
      upd_q   <= upd_d;
    end
  end

  assign state_o    = state_q;
  assign upd_busy_o = upd_q;
  assign upd_done_o = done_o & upd_q;
endmodule

// File: rtl/emr_refresh_seq.sv
module emr_refresh_seq
  import emr_seq_pkg::*;
#(
  parameter int unsigned CW      = 4,
  parameter int unsigned AW      = 13,
  parameter int unsigned BW      = 2,
  parameter int unsigned PRE_BIT = 10,
  parameter int unsigned EMR_BA  = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          refresh_req_i,
  input  logic          cfg_changed_i,
  input  logic [2:0]    pasr_i,
  input  logic [1:0]    tcr_i,
  input  logic [1:0]    ds_i,
  input  logic [CW-1:0] t_rp_i,
  input  logic [CW-1:0] t_mrd_i,
  input  logic [CW-1:0] t_rfc_i,
  output logic [2:0]    cmd_o,
  output logic [BW-1:0] ba_o,
  output logic [AW-1:0] addr_o,
  output logic          cke_o,
  output logic          done_o
);
  localparam int unsigned FW = 7;

  seq_state_e    state;
  logic          pending, upd_busy, upd_done;
  logic          tmr_load, tmr_zero;
  logic [CW-1:0] tmr_val;
  logic [FW-1:0] emr_field;

  emr_pending_flag u_pend (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .change_i   (cfg_changed_i),
    .upd_busy_i (upd_busy),
    .upd_done_i (upd_done),
    .pending_o  (pending)
  );

  emr_gap_timer #(.CW(CW)) u_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  emr_seq_fsm #(.CW(CW)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (refresh_req_i),
    .pending_i  (pending),
    .t_rp_i     (t_rp_i),
    .t_mrd_i    (t_mrd_i),
    .t_rfc_i    (t_rfc_i),
    .tmr_zero_i (tmr_zero),
    .tmr_load_o (tmr_load),
    .tmr_val_o  (tmr_val),
    .state_o    (state),
    .upd_busy_o (upd_busy),
    .done_o     (done_o),
    .upd_done_o (upd_done)
  );

  assign emr_field = {ds_i, tcr_i, pasr_i};

  always_comb begin
    cmd_o  = CMD_NOP;
    ba_o   = '0;
    addr_o = '0;
    unique case (state)
      ST_PRE: begin
        cmd_o           = CMD_PRE;
        addr_o[PRE_BIT] = 1'b1;
      end
      ST_MRS: begin
        cmd_o         = CMD_MRS;
        ba_o          = BW'(EMR_BA);
        addr_o[FW-1:0] = emr_field;
      end
      ST_REF:  cmd_o = CMD_REF;
      default: ;
    endcase
  end

  assign cke_o = 1'b1;
endmodule

// File: rtl/emr_refresh_seq_chk.sv
module emr_refresh_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] cmd_o,
  input logic [1:0] ba_o,
  input logic       cke_o,
  input logic       done_o
);
  a_r10_cke_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_o == 1'b1);
  a_r8_emr_bank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == 3'b000) |-> (ba_o == 2'd2));
  a_r6_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r6_done_on_nop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cmd_o == 3'b111));
  a_r3_pre_then_mrs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == 3'b010) |=> (cmd_o == 3'b111 || cmd_o == 3'b000));
  a_r5_mrs_then_ref: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == 3'b000) |=> (cmd_o == 3'b111 || cmd_o == 3'b001));
  a_r6_ref_then_nop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == 3'b001) |=> (cmd_o == 3'b111));
endmodule

bind emr_refresh_seq emr_refresh_seq_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .cmd_o  (cmd_o),
  .ba_o   (ba_o),
  .cke_o  (cke_o),
  .done_o (done_o)
);

// File: tb/emr_refresh_seq_test.sv
module emr_refresh_seq_test;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        refresh_req_i = 1'b0, cfg_changed_i = 1'b0;
  logic [2:0]  pasr_i = '0;
  logic [1:0]  tcr_i = '0, ds_i = '0;
  logic [3:0]  t_rp_i = '0, t_mrd_i = '0, t_rfc_i = '0;
  logic [2:0]  cmd_o;
  logic [1:0]  ba_o;
  logic [12:0] addr_o;
  logic        cke_o, done_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  emr_refresh_seq uut (.*);

  always #2 clk_i = ~clk_i;

  task automatic check(string tag, logic [2:0] ec, logic [1:0] eb,
                       logic [12:0] ea, logic ed);
    n_chk++;
    if (cmd_o !== ec || ba_o !== eb || addr_o !== ea || done_o !== ed || cke_o !== 1'b1) begin
      n_fail++;
      $display("FAIL %s: cmd=%b ba=%0d addr=%h done=%b cke=%b expected cmd=%b ba=%0d addr=%h done=%b cke=1",
               tag, cmd_o, ba_o, addr_o, done_o, cke_o, ec, eb, ea, ed);
    end
  endtask

  function automatic int eff(int t);
    return (t == 0) ? 1 : t;
  endfunction

  // one refresh slot; inj_cfg / inj_req: cycle index at which to pulse that input (0 = none)
  task automatic run_slot(bit upd, int rp, int mrd, int rfc, int p, int tc, int d,
                          int inj_cfg, int inj_req, int idle_after);
    int p_mrs, p_ref, p_done;
    string z;
    t_rp_i = 4'(rp); t_mrd_i = 4'(mrd); t_rfc_i = 4'(rfc);
    pasr_i = 3'(p); tcr_i = 2'(tc); ds_i = 2'(d);
    z = (rp == 0 || mrd == 0 || rfc == 0) ? "/R7" : "";
    p_mrs  = 1 + eff(rp);
    p_ref  = upd ? p_mrs + eff(mrd) : 1;
    p_done = p_ref + eff(rfc);
    @(negedge clk_i) refresh_req_i = 1'b1;
    @(negedge clk_i) refresh_req_i = 1'b0;
    for (int k = 1; k <= p_done; k++) begin
      if (upd && k == 1)
        check({"R3/R9", z}, 3'b010, 2'd0, 13'h400, 1'b0);
      else if (upd && k < p_mrs)
        check({"R4", z}, 3'b111, 2'd0, 13'h0, 1'b0);
      else if (upd && k == p_mrs)
        check({"R3/R4/R8", z}, 3'b000, 2'd2, 13'({d[1:0], tc[1:0], p[2:0]}), 1'b0);
      else if (upd && k < p_ref)
        check({"R5", z}, 3'b111, 2'd0, 13'h0, 1'b0);
      else if (k == p_ref)
        check(upd ? {"R3/R5", z} : {"R2", z}, 3'b001, 2'd0, 13'h0, 1'b0);
      else
        check({"R6/R10", z}, 3'b111, 2'd0, 13'h0, k == p_done);
      cfg_changed_i = (k == inj_cfg);
      refresh_req_i = (k == inj_req);
      @(negedge clk_i);
      cfg_changed_i = 1'b0;
      refresh_req_i = 1'b0;
    end
    for (int k = 0; k < idle_after; k++) begin
      check(inj_req != 0 ? "R12" : "R6/R10", 3'b111, 2'd0, 13'h0, 1'b0);
      @(negedge clk_i);
    end
  endtask

  task automatic flag_change();
    @(negedge clk_i) cfg_changed_i = 1'b1;
    @(negedge clk_i) cfg_changed_i = 1'b0;
  endtask

  initial begin
    #1;
    check("R1", 3'b111, 2'd0, 13'h0, 1'b0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    check("R1", 3'b111, 2'd0, 13'h0, 1'b0);
    repeat (2) @(negedge clk_i);
    check("R1", 3'b111, 2'd0, 13'h0, 1'b0);

    // R2: no update pending, sweep recovery time
    for (int i = 0; i < 16; i++) run_slot(0, 3, 3, i, 0, 0, 0, 0, 0, 1);
    // R4: sweep precharge gap
    for (int i = 0; i < 16; i++) begin
      flag_change();
      run_slot(1, i, 2, 3, i % 8, i % 4, (i / 4) % 4, 0, 0, 1);
    end
    // R5: sweep mode-set gap
    for (int i = 0; i < 16; i++) begin
      flag_change();
      run_slot(1, 2, i, 2, 7 - (i % 8), (i + 1) % 4, (i + 2) % 4, 0, 0, 1);
    end
    // R6: sweep recovery time with update
    for (int i = 0; i < 16; i++) begin
      flag_change();
      run_slot(1, 1, 1, i, 5, 2, 1, 0, 0, 1);
    end
    // R7: all zero counts
    flag_change();
    run_slot(1, 0, 0, 0, 3, 1, 2, 0, 0, 1);
    // R11: flag cleared after completion, so next slot is plain
    run_slot(0, 2, 2, 2, 0, 0, 0, 0, 0, 1);
    // R11: change during an update sequence keeps flag set
    flag_change();
    run_slot(1, 3, 3, 3, 1, 1, 1, 2, 0, 1);
    run_slot(1, 2, 2, 2, 6, 3, 3, 0, 0, 1);
    run_slot(0, 2, 2, 2, 0, 0, 0, 0, 0, 1);
    // R12: request during a busy slot is ignored
    run_slot(0, 1, 1, 6, 0, 0, 0, 0, 3, 6);
    flag_change();
    run_slot(1, 4, 4, 4, 2, 0, 3, 0, 5, 6);

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule